// File: doc/BRIEF.md
# ADC Conversion Status and Interrupt Tracker

This block keeps the per-channel bookkeeping for a multi-channel analog-to-digital converter. Each time the converter finishes a sample it presents a one-cycle completion strobe with the channel index and the sample value. The tracker stores the value in that channel's result slot and raises the channel's completion flag. When burst mode is on and the previous result had not been read yet, it also raises the channel's lost-data flag. A second result register always holds the latest sample from any channel, with its own completion and lost-data flags and the channel number.

A small register port gives software access to several words. It can write a control word and an interrupt enable mask. It can read the latest-result register, each channel slot, and a status word that shows every channel's flags at once. Reading a result register clears the flags it reports. Writing the control word also clears the latest-result completion flag. If the converter is busy at that moment, the flag is set instead and a restart pulse goes out. A single level interrupt is raised while any enabled channel has its completion flag set.

Register map (word addresses): 0 control (write bit 0 = burst mode), 1 latest result (read), 2 status (read), 3 interrupt mask (read/write), 4 to 4+NUM_CH-1 channel result slots (read).

Top module: `adc_status_tracker`

## Requirements
- R1: After reset, irq and restart are 0, and the status word, the latest-result register and the mask all read as 0.
- R2: A completion strobe on channel c sets c's DONE flag (bit 31 of its slot) and stores the sample in slot bits DATA_W-1:0.
- R3: Every completion loads the latest-result register: DONE at bit 31, OVERRUN at bit 30, channel index at bits 26:24, sample at bits DATA_W-1:0, bits 29:27 zero.
- R4: Reading a channel slot returns its value from before the read and clears that channel's DONE and OVERRUN flags. OVERRUN is never set without DONE.
- R5: Reading the latest-result register returns its prior value and clears its DONE and OVERRUN flags.
- R6: A control write clears the latest-result DONE flag when conv_busy is 0. When conv_busy is 1 it sets DONE instead, and restart is 1 for exactly the cycle after the write.
- R7: A completion sets OVERRUN on the channel (and on the latest-result register) only when burst mode is on and that DONE flag was still set. Without burst mode a new completion leaves OVERRUN 0.
- R8: The status word has the per-channel DONE flags at bits NUM_CH-1:0, the OVERRUN flags at bits 8+NUM_CH-1:8 and the interrupt flag at bit 16. All other bits are 0, and reading it changes no state.
- R9: irq is a registered level equal to the OR of DONE and mask over all channels, one cycle late. It rises one cycle after an enabled DONE sets and falls one cycle after the last one clears or is masked.
- R10: When a read of a channel slot and a new completion on that channel land in the same cycle, the completion wins and DONE stays set.
- R11: The mask register keeps NUM_CH bits. Wider bits read back as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_valid | input | 1 | One-cycle conversion-complete strobe |
| conv_chan | input | CH_W (3) | Channel of the completed conversion |
| conv_data | input | DATA_W (10) | Sample value |
| conv_busy | input | 1 | Converter has a conversion in progress |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W (4) | Register word address |
| reg_wdata | input | NUM_CH (5) | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| irq | output | 1 | Level interrupt |
| restart | output | 1 | Pulse requesting a new conversion |

## Verification
Flags and stored values change at the clock edge that samples the strobe, so a read issued on the next cycle sees them. Read data appears one edge after reg_rd, and the bench samples it at the falling edge that follows. irq follows the flags one edge later. The bench checks it at two successive falling edges after the trigger, to confirm both the one-cycle lag and the final level. restart is checked at the falling edge right after the control-write edge and again one cycle later.

// File: rtl/adc_trk_pkg.sv
package adc_trk_pkg;
  localparam int REG_W        = 32;
  localparam int ADDR_CTRL    = 0;
  localparam int ADDR_GLOB    = 1;
  localparam int ADDR_STAT    = 2;
  localparam int ADDR_MASK    = 3;
  localparam int ADDR_CH_BASE = 4;
  localparam int RES_DONE_BIT = 31;
  localparam int RES_OVR_BIT  = 30;
  localparam int RES_CH_LSB   = 24;
  localparam int STAT_OVR_LSB = 8;
  localparam int STAT_INT_BIT = 16;
endpackage

// File: rtl/adc_chan_bank.sv
module adc_chan_bank import adc_trk_pkg::*; #(
  parameter int NUM_CH = 5,
  parameter int DATA_W = 10,
  parameter int CH_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cv_valid,
  input  logic [CH_W-1:0]   cv_chan,
  input  logic [DATA_W-1:0] cv_data,
  input  logic              burst,
  input  logic [NUM_CH-1:0] rd_clr,
  input  logic              rd_en,
  input  logic [CH_W-1:0]   rd_idx,
  output logic [NUM_CH-1:0] done_o,
  output logic [NUM_CH-1:0] ovr_o,
  output logic [REG_W-1:0]  word_o
);
  logic [DATA_W-1:0] mem [NUM_CH];
  logic [DATA_W-1:0] mem_q;
  logic              snap_done, snap_ovr;

  // sample storage, no reset, synchronous read-before-write
  always_ff @(posedge clk) begin
    if (cv_valid && (32'(cv_chan) < NUM_CH)) mem[cv_chan] <= cv_data;
    if (rd_en) mem_q <= mem[rd_idx];
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        done_o[g] <= 1'b0;
        ovr_o[g]  <= 1'b0;
      end else if (cv_valid && (cv_chan == CH_W'(g))) begin
        done_o[g] <= 1'b1;
        ovr_o[g]  <= burst & done_o[g];
      end else if (rd_clr[g]) begin
        done_o[g] <= 1'b0;
        ovr_o[g]  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_done <= 1'b0;
      snap_ovr  <= 1'b0;
    end else if (rd_en) begin
      snap_done <= done_o[rd_idx];
      snap_ovr  <= ovr_o[rd_idx];
    end
  end

  always_comb begin
    word_o               = '0;
    word_o[RES_DONE_BIT] = snap_done;
    word_o[RES_OVR_BIT]  = snap_ovr;
    word_o[DATA_W-1:0]   = mem_q;
  end
endmodule

// File: rtl/adc_glob_reg.sv
module adc_glob_reg import adc_trk_pkg::*; #(
  parameter int DATA_W = 10,
  parameter int CH_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cv_valid,
  input  logic [CH_W-1:0]   cv_chan,
  input  logic [DATA_W-1:0] cv_data,
  input  logic              ctrl_wr,
  input  logic              ctrl_burst,
  input  logic              busy,
  input  logic              rd_clr,
  output logic              burst_o,
  output logic              restart_o,
  output logic              done_o,
  output logic [REG_W-1:0]  word_o
);
  logic              ovr_q;
  logic [CH_W-1:0]   chan_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      burst_o   <= 1'b0;
      restart_o <= 1'b0;
      done_o    <= 1'b0;
      ovr_q     <= 1'b0;
      chan_q    <= '0;
      data_q    <= '0;
    end else begin
      restart_o <= ctrl_wr & busy;
      if (ctrl_wr) burst_o <= ctrl_burst;
      if (cv_valid) begin
        done_o <= 1'b1;
        ovr_q  <= burst_o & done_o;
        chan_q <= cv_chan;
        data_q <= cv_data;
      end else if (ctrl_wr) begin
        done_o <= busy;
      end else if (rd_clr) begin
        done_o <= 1'b0;
        ovr_q  <= 1'b0;
      end
    end
  end

  always_comb begin
    word_o                          = '0;
    word_o[RES_DONE_BIT]            = done_o;
    word_o[RES_OVR_BIT]             = ovr_q;
    word_o[RES_CH_LSB +: CH_W]      = chan_q;
    word_o[DATA_W-1:0]              = data_q;
  end
endmodule

// File: rtl/adc_irq_gen.sv
module adc_irq_gen #(
  parameter int NUM_CH = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mask_wr,
  input  logic [NUM_CH-1:0] mask_in,
  input  logic [NUM_CH-1:0] done_vec,
  output logic [NUM_CH-1:0] mask_o,
  output logic              flag_o,
  output logic              irq_o
);
  assign flag_o = |(done_vec & mask_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_o <= '0;
      irq_o  <= 1'b0;
    end else begin
      if (mask_wr) mask_o <= mask_in;
      irq_o <= flag_o;
    end
  end
endmodule

// File: rtl/adc_status_tracker.sv
module adc_status_tracker import adc_trk_pkg::*; #(
  parameter int NUM_CH = 5,
  parameter int DATA_W = 10,
  parameter int ADDR_W = 4,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_valid,
  input  logic [CH_W-1:0]   conv_chan,
  input  logic [DATA_W-1:0] conv_data,
  input  logic              conv_busy,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NUM_CH-1:0] reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq,
  output logic              restart
);
  logic              is_ctrl, is_glob, is_stat, is_mask, ch_hit;
  logic [ADDR_W-1:0] ch_off;
  logic [NUM_CH-1:0] rd_clr, ch_done, ch_ovr, mask;
  logic [REG_W-1:0]  bank_word, glob_word, stat_word, rdata_q;
  logic              burst, glob_done, int_flag, ch_sel_q;

  assign is_ctrl = reg_addr == ADDR_W'(ADDR_CTRL);
  assign is_glob = reg_addr == ADDR_W'(ADDR_GLOB);
  assign is_stat = reg_addr == ADDR_W'(ADDR_STAT);
  assign is_mask = reg_addr == ADDR_W'(ADDR_MASK);
  assign ch_off  = reg_addr - ADDR_W'(ADDR_CH_BASE);
  assign ch_hit  = (reg_addr >= ADDR_W'(ADDR_CH_BASE)) && (ch_off < ADDR_W'(NUM_CH));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_clr
    assign rd_clr[g] = reg_rd && ch_hit && (ch_off == ADDR_W'(g));
  end

  adc_chan_bank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CH_W(CH_W)) u_bank (
    .clk(clk), .rst(rst), .cv_valid(conv_valid), .cv_chan(conv_chan),
    .cv_data(conv_data), .burst(burst), .rd_clr(rd_clr),
    .rd_en(reg_rd && ch_hit), .rd_idx(ch_off[CH_W-1:0]),
    .done_o(ch_done), .ovr_o(ch_ovr), .word_o(bank_word)
  );

  adc_glob_reg #(.DATA_W(DATA_W), .CH_W(CH_W)) u_glob (
    .clk(clk), .rst(rst), .cv_valid(conv_valid), .cv_chan(conv_chan),
    .cv_data(conv_data), .ctrl_wr(reg_wr && is_ctrl), .ctrl_burst(reg_wdata[0]),
    .busy(conv_busy), .rd_clr(reg_rd && is_glob), .burst_o(burst),
    .restart_o(restart), .done_o(glob_done), .word_o(glob_word)
  );

  adc_irq_gen #(.NUM_CH(NUM_CH)) u_irq (
    .clk(clk), .rst(rst), .mask_wr(reg_wr && is_mask), .mask_in(reg_wdata),
    .done_vec(ch_done), .mask_o(mask), .flag_o(int_flag), .irq_o(irq)
  );

  always_comb begin
    stat_word                           = '0;
    stat_word[NUM_CH-1:0]               = ch_done;
    stat_word[STAT_OVR_LSB +: NUM_CH]   = ch_ovr;
    stat_word[STAT_INT_BIT]             = int_flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      ch_sel_q <= 1'b0;
    end else if (reg_rd) begin
      ch_sel_q <= ch_hit;
      if (is_glob)      rdata_q <= glob_word;
      else if (is_stat) rdata_q <= stat_word;
      else if (is_mask) rdata_q <= REG_W'(mask);
      else              rdata_q <= '0;
    end
  end

  assign reg_rdata = ch_sel_q ? bank_word : rdata_q;
endmodule

// File: rtl/adc_status_checker.sv
module adc_status_checker #(
  parameter int NUM_CH = 5,
  parameter int CH_W   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              conv_valid,
  input logic [CH_W-1:0]   conv_chan,
  input logic              burst,
  input logic [NUM_CH-1:0] done_vec,
  input logic [NUM_CH-1:0] ovr_vec,
  input logic [NUM_CH-1:0] mask,
  input logic              irq,
  input logic              restart,
  input logic              ctrl_wr,
  input logic              busy,
  input logic              glob_done,
  input logic [31:0]       stat_word
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    AST_DONE_ON_CONV: assert property (@(posedge clk) disable iff (rst)
      (conv_valid && conv_chan == CH_W'(g)) |=> done_vec[g]); // R2
  end

  AST_GLOB_DONE_ON_CONV: assert property (@(posedge clk) disable iff (rst)
    conv_valid |=> glob_done); // R3

  AST_OVR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    (ovr_vec & ~done_vec) == '0); // R4

  AST_OVR_NEEDS_BURST: assert property (@(posedge clk) disable iff (rst)
    (|(ovr_vec & ~$past(ovr_vec))) |-> $past(burst)); // R7

  AST_STATUS_ZEROS: assert property (@(posedge clk) disable iff (rst)
    (stat_word & ~((32'(1) << 16) | (((32'(1) << NUM_CH) - 1) << 8)
                   | ((32'(1) << NUM_CH) - 1))) == '0); // R8

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|(done_vec & mask))); // R9

  AST_RESTART_CAUSE: assert property (@(posedge clk) disable iff (rst)
    restart |-> $past(ctrl_wr && busy)); // R6
endmodule

bind adc_status_tracker adc_status_checker #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst(rst), .conv_valid(conv_valid), .conv_chan(conv_chan),
  .burst(burst), .done_vec(ch_done), .ovr_vec(ch_ovr), .mask(mask),
  .irq(irq), .restart(restart), .ctrl_wr(reg_wr && is_ctrl), .busy(conv_busy),
  .glob_done(glob_done), .stat_word(stat_word)
);

// File: tb/sim_adc_status_tracker.sv
module sim_adc_status_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int TIMEOUT    = 20000;

  typedef struct packed {
    logic [1:0]  op;    // 0 convert, 1 write, 2 read-check
    logic [3:0]  addr;  // register address, or channel for convert
    logic [31:0] val;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 4'd2, 32'h155,        32'h0,          8'd2},  // R2 convert ch2
    '{2'd2, 4'd6, 32'h0,          32'h8000_0155,  8'd2},  // R2 slot shows DONE
    '{2'd2, 4'd6, 32'h0,          32'h0000_0155,  8'd4},  // R4 cleared by read
    '{2'd2, 4'd1, 32'h0,          32'h8200_0155,  8'd3},  // R3 latest result
    '{2'd2, 4'd1, 32'h0,          32'h0200_0155,  8'd5},  // R5 cleared by read
    '{2'd1, 4'd0, 32'h1,          32'h0,          8'd7},  // R7 burst on
    '{2'd0, 4'd1, 32'h0AA,        32'h0,          8'd7},
    '{2'd0, 4'd1, 32'h0BB,        32'h0,          8'd7},  // R7 overwrite unread
    '{2'd2, 4'd2, 32'h0,          32'h0000_0202,  8'd8},  // R8 status
    '{2'd2, 4'd1, 32'h0,          32'hC100_00BB,  8'd7},  // R7 latest overrun
    '{2'd1, 4'd3, 32'h1F,         32'h0,          8'd11},
    '{2'd2, 4'd3, 32'h0,          32'h0000_001F,  8'd11}, // R11 mask readback
    '{2'd2, 4'd2, 32'h0,          32'h0001_0202,  8'd8},  // R8 no side effect, int bit
    '{2'd2, 4'd5, 32'h0,          32'hC000_00BB,  8'd4},  // R4 slot with overrun
    '{2'd2, 4'd2, 32'h0,          32'h0000_0000,  8'd4},  // R4 flags gone
    '{2'd1, 4'd0, 32'h0,          32'h0,          8'd7},  // burst off
    '{2'd0, 4'd3, 32'h3FF,        32'h0,          8'd7},
    '{2'd0, 4'd3, 32'h001,        32'h0,          8'd7},
    '{2'd2, 4'd7, 32'h0,          32'h8000_0001,  8'd7}   // R7 no overrun
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        conv_valid = 1'b0;
  logic [2:0]  conv_chan = '0;
  logic [9:0]  conv_data = '0;
  logic        conv_busy = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [4:0]  reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, restart;

  int n_chk  = 0;
  int n_fail = 0;
  bit done_run = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_status_tracker u0 (
    .clk(clk), .rst(rst), .conv_valid(conv_valid), .conv_chan(conv_chan),
    .conv_data(conv_data), .conv_busy(conv_busy), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .restart(restart)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one operation: drive at a falling edge, release and check at the next
  task automatic run_op(input logic [1:0] op, input logic [3:0] addr,
                        input logic [31:0] val, input logic [31:0] exp, input string req);
    @(negedge clk);
    case (op)
      2'd0: begin conv_valid = 1'b1; conv_chan = addr[2:0]; conv_data = val[9:0]; end
      2'd1: begin reg_wr = 1'b1; reg_addr = addr; reg_wdata = val[4:0]; end
      default: begin reg_rd = 1'b1; reg_addr = addr; end
    endcase
    @(negedge clk);
    conv_valid = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
    if (op == 2'd2) check(req, reg_rdata, exp);
  endtask

  initial begin
    repeat (TIMEOUT) @(posedge clk);
    if (!done_run) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    check("R1 irq", 32'(irq), 32'h0);
    check("R1 restart", 32'(restart), 32'h0);
    run_op(2'd2, 4'd2, 0, 32'h0, "R1 status");
    run_op(2'd2, 4'd1, 0, 32'h0, "R1 latest");
    run_op(2'd2, 4'd3, 0, 32'h0, "R1 mask");

    for (int i = 0; i < NV; i++)
      run_op(VEC[i].op, VEC[i].addr, VEC[i].val, VEC[i].exp,
             $sformatf("R%0d vec%0d", VEC[i].req, i));

    // R11 wide mask value truncated to NUM_CH bits: write all ones
    run_op(2'd1, 4'd3, 32'h1F, 0, "R11");
    run_op(2'd2, 4'd3, 0, 32'h0000_001F, "R11 mask");

    // R9 irq lag: completion on enabled ch4
    @(negedge clk);
    conv_valid = 1'b1; conv_chan = 3'd4; conv_data = 10'h044;
    @(negedge clk);
    conv_valid = 1'b0;
    check("R9 irq lag", 32'(irq), 32'h0);
    @(negedge clk);
    check("R9 irq rise", 32'(irq), 32'h1);
    run_op(2'd1, 4'd3, 32'h0, 0, "R9");
    check("R9 irq hold", 32'(irq), 32'h1);
    @(negedge clk);
    check("R9 irq fall", 32'(irq), 32'h0);

    // R10 read-clear and completion in the same cycle on ch4
    @(negedge clk);
    conv_valid = 1'b1; conv_chan = 3'd4; conv_data = 10'h0AB;
    reg_rd = 1'b1; reg_addr = 4'd8;
    @(negedge clk);
    conv_valid = 1'b0; reg_rd = 1'b0;
    check("R10 old value", reg_rdata, 32'h8000_0044);
    run_op(2'd2, 4'd8, 0, 32'h8000_00AB, "R10 done kept");

    // R6 control write, idle converter
    run_op(2'd1, 4'd0, 32'h0, 0, "R6");
    check("R6 no restart", 32'(restart), 32'h0);
    run_op(2'd2, 4'd1, 0, 32'h0400_00AB, "R6 cleared");

    // R6 control write while busy
    conv_busy = 1'b1;
    run_op(2'd1, 4'd0, 32'h0, 0, "R6");
    check("R6 restart", 32'(restart), 32'h1);
    conv_busy = 1'b0;
    @(negedge clk);
    check("R6 restart pulse", 32'(restart), 32'h0);
    run_op(2'd2, 4'd1, 0, 32'h8400_00AB, "R6 set busy");

    done_run = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule